// File: doc/BRIEF.md
# Paired Character FIFO with Level Triggers

This block sits between a serial port's bus registers and its character-level transmitter and receiver. It holds one transmit queue and one receive queue, each 16 entries deep by default. Software (or a DMA engine) pushes 9-bit characters into the transmit queue, and the transmitter drains them through a valid/ready handshake. The receiver hands over each character with its framing, parity and noise flags. Software takes these from the receive queue either destructively (pop) or by looking at the head without removing it.

Each queue reports its fill level and the usual empty and full flags. Each can be emptied at once by a flush pulse or held empty by clearing its enable. Pushing into a full queue or draining an empty transmit queue sets a sticky error flag, which is cleared by writing one. Level comparators against programmable thresholds, together with the two error flags, form four interrupt sources. These sources are gated by enables that have separate set and clear ports. Two DMA request lines follow the queue occupancy.

Top module: `sfq_fifo_pair`

## Requirements
- R1: Each queue holds at most DEPTH (16) entries. Its level output counts 0 to 16. tx_empty_o is high exactly at level 0, tx_notfull_o is high below 16, rx_notempty_o is high above 0, and rx_full_o is high at 16.
- R2: Transmit characters reach txc_data_o in push order. txc_valid_o is high while the transmit queue holds data. The head is removed on a cycle with txc_valid_o and txc_ready_i both high.
- R3: A host push into a full transmit queue is dropped, leaves the stored entries unchanged and sets tx_err_o. A cycle with txc_ready_i high while the enabled transmit queue is empty also sets tx_err_o.
- R4: A receiver push stores a 12-bit entry with noise at bit 11, parity error at bit 10, framing error at bit 9 and data at bits 8:0. A push into a full receive queue is dropped, keeps the contents and sets rx_err_o.
- R5: tx_err_o and rx_err_o hold until err_clr_i bit 0 (transmit) or bit 1 (receive) is pulsed. A new error event in the same cycle as the clear keeps the flag set.
- R6: A flush pulse leaves that queue at level 0 on the next cycle. While its enable is low, a queue stays empty and ignores pushes without raising an error.
- R7: rx_peek_o shows the receive head without removing it. A pop loads that head into rx_rdata_o and removes it. A pop on an empty queue leaves rx_rdata_o and the level unchanged.
- R8: With tx_trig_en_i set, the transmit level event is active while tx_level_o is at most tx_thr_i. Threshold 0 therefore means empty, and threshold 15 means not full.
- R9: With rx_trig_en_i set, the receive level event is active while rx_level_o is at least rx_thr_i + 1. Threshold 15 therefore means full.
- R10: Interrupt enables use bit 0 for transmit error, bit 1 for receive error, bit 2 for transmit level and bit 3 for receive level. A 1 on ien_set_i sets the enable bit and a 1 on ien_clr_i clears it; clear wins when both are high. int_stat_o is the AND of events and enables, and irq_o is its OR.
- R11: tx_dma_o is high while tx_dma_en_i is set and the enabled transmit queue is not full. rx_dma_o is high while rx_dma_en_i is set and the receive queue is not empty.
- R12: After reset, both queues are empty, both error flags and all enables are 0, and rx_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Transmit queue enable |
| rx_en_i | input | 1 | Receive queue enable |
| tx_flush_i | input | 1 | Empty the transmit queue |
| rx_flush_i | input | 1 | Empty the receive queue |
| host_wr_i | input | 1 | Host push into transmit queue |
| host_wdata_i | input | DW (9) | Character to push |
| host_rd_i | input | 1 | Host pop from receive queue |
| rx_peek_o | output | DW+3 (12) | Receive head, not removed |
| rx_rdata_o | output | DW+3 (12) | Entry taken by the last successful pop |
| txc_valid_o | output | 1 | Transmit character available |
| txc_data_o | output | DW (9) | Transmit head character |
| txc_ready_i | input | 1 | Transmitter requests a character |
| rxc_valid_i | input | 1 | Receiver delivers a character |
| rxc_data_i | input | DW (9) | Received character |
| rxc_ferr_i | input | 1 | Framing error flag |
| rxc_perr_i | input | 1 | Parity error flag |
| rxc_noise_i | input | 1 | Noise flag |
| rxc_ready_o | output | 1 | Receive queue accepting |
| tx_level_o | output | LW (5) | Transmit fill level |
| rx_level_o | output | LW (5) | Receive fill level |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_notfull_o | output | 1 | Transmit queue not full |
| rx_notempty_o | output | 1 | Receive queue not empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_trig_en_i | input | 1 | Transmit level trigger enable |
| tx_thr_i | input | AW (4) | Transmit trigger threshold |
| rx_trig_en_i | input | 1 | Receive level trigger enable |
| rx_thr_i | input | AW (4) | Receive trigger threshold |
| err_clr_i | input | 2 | Clear error flags (bit 0 tx, bit 1 rx) |
| tx_err_o | output | 1 | Sticky transmit error |
| rx_err_o | output | 1 | Sticky receive error |
| ien_set_i | input | 4 | Set interrupt enables |
| ien_clr_i | input | 4 | Clear interrupt enables |
| ien_o | output | 4 | Current interrupt enables |
| int_stat_o | output | 4 | Enabled interrupt events |
| irq_o | output | 1 | Interrupt request |
| tx_dma_en_i | input | 1 | Allow transmit DMA request |
| rx_dma_en_i | input | 1 | Allow receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |
| rx_dma_o | output | 1 | Receive DMA request |

## Verification
The embedded properties assume that the transmitter raises txc_ready_i only when it wants a character, so every ready seen on an empty queue is a real underflow. They also assume that flush and enable changes are synchronous to clk. The bench drives every input at the falling edge and holds each request for a single cycle. Thresholds and enables change only between pushes. The bench never pushes more than one character past full, so the overflow and stale-head properties cover the exact corner the stimulus reaches.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int FLAG_W  = 3;
  localparam int NUM_IRQ = 4;
  localparam int IRQ_TXERR = 0;
  localparam int IRQ_RXERR = 1;
  localparam int IRQ_TXLVL = 2;
  localparam int IRQ_RXLVL = 3;
  localparam int ERR_W = 2;
endpackage

// File: rtl/sfq_ring.sv
module sfq_ring #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          clr, do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign clr     = flush | ~en;
  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign do_pop  = pop & ~empty & ~clr;
  assign do_push = push & ~clr & (~full | do_pop);
  assign ovf     = push & ~clr & full & ~do_pop;
  assign level   = cnt;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R1: fill never exceeds capacity
  a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(DEPTH));
  // R3/R4: a dropped push keeps the queue exactly full
  a_r3_ovf_keeps_full: assert property (@(posedge clk) disable iff (rst)
    ovf |=> full);
  // R7: popping an empty queue leaves it empty
  a_r7_empty_pop_still: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
  // R6: flush or disable empties the queue on the next cycle
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
endmodule

// File: rtl/sfq_irq.sv
module sfq_irq
  import sfq_pkg::*;
#(
  parameter int LW = 5,
  parameter int TW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LW-1:0]      tx_level,
  input  logic [LW-1:0]      rx_level,
  input  logic               tx_trig_en,
  input  logic [TW-1:0]      tx_thr,
  input  logic               rx_trig_en,
  input  logic [TW-1:0]      rx_thr,
  input  logic               tx_ev,
  input  logic               rx_ev,
  input  logic [ERR_W-1:0]   err_clr,
  input  logic [NUM_IRQ-1:0] ien_set,
  input  logic [NUM_IRQ-1:0] ien_clr,
  output logic               tx_err,
  output logic               rx_err,
  output logic [NUM_IRQ-1:0] ien,
  output logic [NUM_IRQ-1:0] int_stat,
  output logic               irq
);
  logic tx_hit, rx_hit;
  logic [NUM_IRQ-1:0] events;

  assign tx_hit = tx_trig_en & (tx_level <= LW'(tx_thr));
  assign rx_hit = rx_trig_en & (rx_level >  LW'(rx_thr));

  always_comb begin
    events = '0;
    events[IRQ_TXERR] = tx_err;
    events[IRQ_RXERR] = rx_err;
    events[IRQ_TXLVL] = tx_hit;
    events[IRQ_RXLVL] = rx_hit;
  end

  assign int_stat = events & ien;
  assign irq      = |int_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_err <= 1'b0;
      rx_err <= 1'b0;
      ien    <= '0;
    end else begin
      tx_err <= tx_ev | (tx_err & ~err_clr[0]);
      rx_err <= rx_ev | (rx_err & ~err_clr[1]);
      ien    <= (ien | ien_set) & ~ien_clr;
    end
  end

  // R5: error flags stay until cleared
  a_r5_tx_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !err_clr[0]) |=> tx_err);
  a_r5_rx_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !err_clr[1]) |=> rx_err);
  // R5: a new event beats the clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
    tx_ev |=> tx_err);
  // R10: a request needs at least one enable
  a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ien != '0));

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_ien_chk
    // R10: clear beats set on each enable bit
    a_r10_clr_wins: assert property (@(posedge clk) disable iff (rst)
      ien_clr[k] |=> !ien[k]);
  end
endmodule

// File: rtl/sfq_fifo_pair.sv
module sfq_fifo_pair
  import sfq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int RW = DW + FLAG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic               tx_flush_i,
  input  logic               rx_flush_i,
  input  logic               host_wr_i,
  input  logic [DW-1:0]      host_wdata_i,
  input  logic               host_rd_i,
  output logic [RW-1:0]      rx_peek_o,
  output logic [RW-1:0]      rx_rdata_o,
  output logic               txc_valid_o,
  output logic [DW-1:0]      txc_data_o,
  input  logic               txc_ready_i,
  input  logic               rxc_valid_i,
  input  logic [DW-1:0]      rxc_data_i,
  input  logic               rxc_ferr_i,
  input  logic               rxc_perr_i,
  input  logic               rxc_noise_i,
  output logic               rxc_ready_o,
  output logic [LW-1:0]      tx_level_o,
  output logic [LW-1:0]      rx_level_o,
  output logic               tx_empty_o,
  output logic               tx_notfull_o,
  output logic               rx_notempty_o,
  output logic               rx_full_o,
  input  logic               tx_trig_en_i,
  input  logic [AW-1:0]      tx_thr_i,
  input  logic               rx_trig_en_i,
  input  logic [AW-1:0]      rx_thr_i,
  input  logic [ERR_W-1:0]   err_clr_i,
  output logic               tx_err_o,
  output logic               rx_err_o,
  input  logic [NUM_IRQ-1:0] ien_set_i,
  input  logic [NUM_IRQ-1:0] ien_clr_i,
  output logic [NUM_IRQ-1:0] ien_o,
  output logic [NUM_IRQ-1:0] int_stat_o,
  output logic               irq_o,
  input  logic               tx_dma_en_i,
  input  logic               rx_dma_en_i,
  output logic               tx_dma_o,
  output logic               rx_dma_o
);
  logic          tx_full, tx_empty, tx_ovf, tx_unf;
  logic          rx_full, rx_empty, rx_ovf;
  logic [RW-1:0] rx_entry, rx_head;

  sfq_ring #(.W(DW), .DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst(rst), .en(tx_en_i), .flush(tx_flush_i),
    .push(host_wr_i), .din(host_wdata_i), .pop(txc_ready_i),
    .head(txc_data_o), .level(tx_level_o), .full(tx_full),
    .empty(tx_empty), .ovf(tx_ovf)
  );

  assign rx_entry = {rxc_noise_i, rxc_perr_i, rxc_ferr_i, rxc_data_i};

  sfq_ring #(.W(RW), .DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst(rst), .en(rx_en_i), .flush(rx_flush_i),
    .push(rxc_valid_i), .din(rx_entry), .pop(host_rd_i),
    .head(rx_head), .level(rx_level_o), .full(rx_full),
    .empty(rx_empty), .ovf(rx_ovf)
  );

  assign tx_unf = txc_ready_i & tx_en_i & ~tx_flush_i & tx_empty;

  sfq_irq #(.LW(LW), .TW(AW)) u_irq (
    .clk(clk), .rst(rst),
    .tx_level(tx_level_o), .rx_level(rx_level_o),
    .tx_trig_en(tx_trig_en_i), .tx_thr(tx_thr_i),
    .rx_trig_en(rx_trig_en_i), .rx_thr(rx_thr_i),
    .tx_ev(tx_ovf | tx_unf), .rx_ev(rx_ovf),
    .err_clr(err_clr_i), .ien_set(ien_set_i), .ien_clr(ien_clr_i),
    .tx_err(tx_err_o), .rx_err(rx_err_o), .ien(ien_o),
    .int_stat(int_stat_o), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                        rx_rdata_o <= '0;
    else if (host_rd_i && !rx_empty) rx_rdata_o <= rx_head;
  end

  assign rx_peek_o     = rx_head;
  assign txc_valid_o   = ~tx_empty;
  assign rxc_ready_o   = rx_en_i;
  assign tx_empty_o    = tx_empty;
  assign tx_notfull_o  = ~tx_full;
  assign rx_notempty_o = ~rx_empty;
  assign rx_full_o     = rx_full;
  assign tx_dma_o      = tx_dma_en_i & tx_en_i & ~tx_full;
  assign rx_dma_o      = rx_dma_en_i & ~rx_empty;

  // R11: transmit DMA never requests into a full queue
  a_r11_tx_dma_room: assert property (@(posedge clk) disable iff (rst)
    tx_dma_o |-> (tx_level_o != LW'(DEPTH)));
  // R7: read data only moves on a pop
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd_i |=> $stable(rx_rdata_o));
  // R2: a handshake removes exactly one entry when nothing else happens
  a_r2_pop_one: assert property (@(posedge clk) disable iff (rst)
    (txc_valid_o && txc_ready_i && !host_wr_i && tx_en_i && !tx_flush_i)
      |=> (tx_level_o == $past(tx_level_o) - 1'b1));
endmodule

// File: tb/sfq_fifo_pair_bench.sv
module sfq_fifo_pair_bench;
  localparam int DEPTH = 16;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int LW = 5;
  localparam int RW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_en = 0, rx_en = 0, tx_flush = 0, rx_flush = 0;
  logic host_wr = 0, host_rd = 0, txc_ready = 0, rxc_valid = 0;
  logic [DW-1:0] host_wdata = '0, rxc_data = '0;
  logic ferr = 0, perr = 0, noise = 0;
  logic tx_trig_en = 0, rx_trig_en = 0;
  logic [AW-1:0] tx_thr = '0, rx_thr = '0;
  logic [1:0] err_clr = '0;
  logic [3:0] ien_set = '0, ien_clr = '0;
  logic tx_dma_en = 0, rx_dma_en = 0;
  logic [RW-1:0] rx_peek, rx_rdata;
  logic txc_valid, rxc_ready, tx_empty, tx_notfull, rx_notempty, rx_full;
  logic [DW-1:0] txc_data;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_err, rx_err, irq, tx_dma, rx_dma;
  logic [3:0] ien, int_stat;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sfq_fifo_pair u_sfq_fifo_pair (
    .clk(clk), .rst(rst), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_flush_i(tx_flush), .rx_flush_i(rx_flush),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .rx_peek_o(rx_peek), .rx_rdata_o(rx_rdata),
    .txc_valid_o(txc_valid), .txc_data_o(txc_data), .txc_ready_i(txc_ready),
    .rxc_valid_i(rxc_valid), .rxc_data_i(rxc_data), .rxc_ferr_i(ferr),
    .rxc_perr_i(perr), .rxc_noise_i(noise), .rxc_ready_o(rxc_ready),
    .tx_level_o(tx_level), .rx_level_o(rx_level), .tx_empty_o(tx_empty),
    .tx_notfull_o(tx_notfull), .rx_notempty_o(rx_notempty), .rx_full_o(rx_full),
    .tx_trig_en_i(tx_trig_en), .tx_thr_i(tx_thr),
    .rx_trig_en_i(rx_trig_en), .rx_thr_i(rx_thr),
    .err_clr_i(err_clr), .tx_err_o(tx_err), .rx_err_o(rx_err),
    .ien_set_i(ien_set), .ien_clr_i(ien_clr), .ien_o(ien),
    .int_stat_o(int_stat), .irq_o(irq),
    .tx_dma_en_i(tx_dma_en), .rx_dma_en_i(rx_dma_en),
    .tx_dma_o(tx_dma), .rx_dma_o(rx_dma)
  );

  // fields: [14:10] pushes, [9:6] tx threshold, [5:2] rx threshold,
  // [1] expected tx level event, [0] expected rx level event
  localparam logic [14:0] VEC [6] = '{
    {5'd0,  4'd0,  4'd0,  1'b1, 1'b0},
    {5'd1,  4'd0,  4'd0,  1'b0, 1'b1},
    {5'd5,  4'd5,  4'd5,  1'b1, 1'b0},
    {5'd6,  4'd5,  4'd5,  1'b0, 1'b1},
    {5'd16, 4'd15, 4'd15, 1'b0, 1'b1},
    {5'd15, 4'd15, 4'd15, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tx_push(input logic [DW-1:0] d);
    host_wr = 1; host_wdata = d; cyc(); host_wr = 0;
  endtask

  task automatic rx_push(input logic [RW-1:0] e);
    rxc_valid = 1; rxc_data = e[8:0]; ferr = e[9]; perr = e[10]; noise = e[11];
    cyc();
    rxc_valid = 0; ferr = 0; perr = 0; noise = 0;
  endtask

  task automatic both_push(input logic [DW-1:0] d);
    host_wr = 1; host_wdata = d; rxc_valid = 1; rxc_data = d;
    cyc();
    host_wr = 0; rxc_valid = 0;
  endtask

  task automatic tx_take();
    txc_ready = 1; cyc(); txc_ready = 0;
  endtask

  task automatic rx_pop();
    host_rd = 1; cyc(); host_rd = 0;
  endtask

  task automatic flush_all();
    tx_flush = 1; rx_flush = 1; cyc(); tx_flush = 0; rx_flush = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R12 reset state, R1 flags
    chk("R12 tx_level", 32'(tx_level), 32'd0);
    chk("R12 rx_level", 32'(rx_level), 32'd0);
    chk("R1 tx_empty", 32'(tx_empty), 32'd1);
    chk("R1 rx_notempty", 32'(rx_notempty), 32'd0);
    chk("R12 errors", 32'({tx_err, rx_err}), 32'd0);
    chk("R12 ien", 32'(ien), 32'd0);
    chk("R12 rx_rdata", 32'(rx_rdata), 32'd0);
    chk("R12 irq", 32'(irq), 32'd0);

    tx_en = 1; rx_en = 1; tx_trig_en = 1; rx_trig_en = 1;
    ien_set = 4'hF; cyc(); ien_set = '0;
    chk("R10 ien set", 32'(ien), 32'hF);

    // R8 R9 R1 table walk
    for (int i = 0; i < 6; i++) begin
      logic [14:0] v;
      int n;
      v = VEC[i];
      n = int'(v[14:10]);
      flush_all();
      tx_thr = v[9:6];
      rx_thr = v[5:2];
      for (int k = 0; k < n; k++) both_push(DW'(k));
      chk("R1 tx_level", 32'(tx_level), 32'(n));
      chk("R1 rx_level", 32'(rx_level), 32'(n));
      chk("R1 tx_notfull", 32'(tx_notfull), 32'(n < DEPTH));
      chk("R1 rx_full", 32'(rx_full), 32'(n == DEPTH));
      chk("R8 tx level event", 32'(int_stat[2]), 32'(v[1]));
      chk("R9 rx level event", 32'(int_stat[3]), 32'(v[0]));
      chk("R10 no error bits", 32'(int_stat[1:0]), 32'd0);
    end

    // R2 ordering
    flush_all();
    tx_push(9'h011); tx_push(9'h122); tx_push(9'h0F3);
    chk("R2 valid", 32'(txc_valid), 32'd1);
    chk("R2 head0", 32'(txc_data), 32'h011);
    tx_take();
    chk("R2 head1", 32'(txc_data), 32'h122);
    tx_take();
    chk("R2 head2", 32'(txc_data), 32'h0F3);
    tx_take();
    chk("R2 drained", 32'({txc_valid, tx_level}), 32'd0);
    chk("R3 no err yet", 32'(tx_err), 32'd0);
    // R3 underflow
    tx_take();
    chk("R3 underflow err", 32'(tx_err), 32'd1);
    chk("R10 int tx err", 32'(int_stat[0]), 32'd1);
    chk("R10 irq", 32'(irq), 32'd1);
    err_clr = 2'b01; cyc(); err_clr = '0;
    chk("R5 tx clear", 32'(tx_err), 32'd0);

    // R3 overflow
    flush_all();
    for (int k = 0; k < DEPTH; k++) tx_push(DW'(k));
    chk("R3 full no err", 32'(tx_err), 32'd0);
    tx_push(9'h1AA);
    chk("R3 level stays", 32'(tx_level), 32'd16);
    chk("R3 ovf err", 32'(tx_err), 32'd1);
    chk("R3 head kept", 32'(txc_data), 32'd0);
    for (int k = 0; k < DEPTH - 1; k++) tx_take();
    chk("R3 tail kept", 32'(txc_data), 32'h00F);
    tx_take();
    chk("R3 drained", 32'(tx_level), 32'd0);
    err_clr = 2'b01; cyc(); err_clr = '0;
    // R5 event beats clear
    err_clr = 2'b01; txc_ready = 1; cyc(); err_clr = '0; txc_ready = 0;
    chk("R5 set wins", 32'(tx_err), 32'd1);
    err_clr = 2'b01; cyc(); err_clr = '0;
    chk("R5 cleared", 32'(tx_err), 32'd0);

    // R4 R7 receive entries and peek
    flush_all();
    rx_push(12'hB55);
    chk("R7 peek", 32'(rx_peek), 32'hB55);
    chk("R4 level", 32'(rx_level), 32'd1);
    cyc();
    chk("R7 peek no pop", 32'(rx_level), 32'd1);
    rx_pop();
    chk("R7 rdata", 32'(rx_rdata), 32'hB55);
    chk("R7 popped", 32'(rx_level), 32'd0);
    rx_pop();
    chk("R7 empty pop keeps data", 32'(rx_rdata), 32'hB55);
    chk("R7 empty pop level", 32'(rx_level), 32'd0);
    chk("R7 empty pop no err", 32'(rx_err), 32'd0);
    rx_push(12'h4AA);
    rx_pop();
    chk("R4 parity bit10", 32'(rx_rdata), 32'h4AA);
    // R4 overflow
    for (int k = 0; k < DEPTH + 1; k++) rx_push(RW'(k));
    chk("R4 level full", 32'(rx_level), 32'd16);
    chk("R4 rx err", 32'(rx_err), 32'd1);
    rx_pop();
    chk("R4 head kept", 32'(rx_rdata), 32'd0);
    err_clr = 2'b10; cyc(); err_clr = '0;
    chk("R5 rx clear", 32'(rx_err), 32'd0);

    // R6 flush and disable
    tx_push(9'h001); tx_push(9'h002);
    chk("R6 level2", 32'(tx_level), 32'd2);
    tx_en = 0; cyc();
    chk("R6 disabled empty", 32'({txc_valid, tx_level}), 32'd0);
    tx_push(9'h003);
    chk("R6 ignored push", 32'(tx_level), 32'd0);
    chk("R6 no err", 32'(tx_err), 32'd0);
    tx_en = 1; cyc();
    rx_flush = 1; cyc(); rx_flush = 0;
    chk("R6 rx flush", 32'(rx_level), 32'd0);

    // R11 DMA
    tx_dma_en = 1; rx_dma_en = 1; cyc();
    chk("R11 tx dma empty", 32'(tx_dma), 32'd1);
    chk("R11 rx dma empty", 32'(rx_dma), 32'd0);
    for (int k = 0; k < DEPTH; k++) tx_push(DW'(k));
    chk("R11 tx dma full", 32'(tx_dma), 32'd0);
    rx_push(12'h001);
    chk("R11 rx dma data", 32'(rx_dma), 32'd1);

    // R10 enable set/clear
    ien_clr = 4'hF; cyc(); ien_clr = '0;
    chk("R10 cleared", 32'({irq, ien}), 32'd0);
    rx_thr = 4'd0; cyc();
    chk("R10 masked", 32'(int_stat), 32'd0);
    ien_set = 4'h8; ien_clr = 4'h8; cyc(); ien_set = '0; ien_clr = '0;
    chk("R10 clear wins", 32'(ien), 32'd0);
    ien_set = 4'h8; cyc(); ien_set = '0;
    chk("R10 rx level int", 32'(int_stat), 32'h8);
    chk("R10 irq on", 32'(irq), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule